// File: doc/BRIEF.md
# Reorder Buffer with Backward-Walk Rollback

This block is a circular window of renamed instructions. Each one stays in it from rename until commit. Rename writes an entry at the tail. Each entry holds the logical destination, the freshly allocated physical tag, the tag that allocation displaced, two source tags and a ready flag for each source. A per-entry status moves through waiting, ready, executing and done. Writebacks broadcast a physical tag, which wakes every matching source and marks the addressed slot as done.

Execution stays in order. The issue port offers only the oldest entry, or the entry after it once the oldest has finished. The commit port retires the oldest entry when it is done and reports the displaced tag so it can be released.

A finished entry that carries a mispredict flag does not commit right away. It triggers a rollback that walks backward from the youngest entry, one entry per cycle. Each step tells the rename tables to restore the logical register to its displaced tag and to free the entry's new tag. When the walk reaches the mispredicting entry, a one-cycle redirect carries the corrected fetch address and a new epoch. That entry then commits normally, and the next insertion lands in the slot right after it.

Top module: `reorder_window`

## Requirements
- R1: `in_ready` is high exactly when fewer than DEPTH entries are held and no rollback is running. An insert taken at a clock edge goes into slot `in_idx`. `in_idx` advances by one modulo DEPTH per accepted insert and starts at 0 after reset. An insert attempted while `in_ready` is low leaves no trace.
- R2: A committed entry reports the logical register, new tag and displaced tag it was inserted with, and entries commit in insertion order.
- R3: An entry whose sources are not all ready is never offered for issue.
- R4: A writeback (`wb_valid`, `wb_ptag`) sets the ready flag of every held source whose tag matches, and this includes an entry being inserted in the same cycle. An entry is offered in the cycle after its last source wakes. A writeback also marks slot `wb_idx` done. When that slot is not occupied, only the wakeup has an effect.
- R5: Issue offers the oldest entry when it is ready. It offers the next entry only when the oldest is done and not mispredicted and the next is ready. An entry that has been taken is not offered again.
- R6: `cm_valid` is high only when the oldest entry is done without a mispredict, and that entry leaves at the same edge.
- R7: A done oldest entry with a mispredict flag starts a rollback at the next edge. While the rollback runs, `replay_busy` is high and `in_ready`, `iss_valid` and `cm_valid` are low.
- R8: The rollback presents the youngest remaining entry on `rb_*` once per cycle (logical register, displaced tag to restore, new tag to free). It stops before the mispredicting entry and takes no step when no younger entry exists.
- R9: The rollback ends with `redir_valid` high for exactly one cycle, carrying the target given with the mispredict and an epoch one greater (modulo 2^EPOCH_W) than the previous one. The epoch is 0 after reset, so the first redirect carries 1.
- R10: In the cycle after the redirect, the mispredicting entry commits, and the next insert goes into the slot just after it.
- R11: Occupancy stays correct across wrap-around: after the slot index wraps, the buffer still accepts exactly DEPTH entries and drains to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Rename offers an entry |
| in_ready | output | 1 | Entry can be accepted |
| in_idx | output | $clog2(DEPTH) | Slot the next insert occupies |
| in_lreg | input | LREG_W | Logical destination |
| in_ptag | input | PTAG_W | Newly allocated physical tag |
| in_prev_ptag | input | PTAG_W | Tag displaced by the allocation |
| in_src_a | input | PTAG_W | First source tag |
| in_src_a_rdy | input | 1 | First source already available |
| in_src_b | input | PTAG_W | Second source tag |
| in_src_b_rdy | input | 1 | Second source already available |
| wb_valid | input | 1 | Writeback event |
| wb_idx | input | $clog2(DEPTH) | Slot that finished |
| wb_ptag | input | PTAG_W | Tag broadcast for wakeup |
| wb_mispredict | input | 1 | Finished instruction mispredicted |
| wb_target | input | PC_W | Corrected fetch address |
| iss_valid | output | 1 | An entry is offered for execution |
| iss_take | input | 1 | Offered entry is taken |
| iss_idx | output | $clog2(DEPTH) | Slot of the offered entry |
| iss_ptag | output | PTAG_W | Destination tag of offered entry |
| iss_src_a | output | PTAG_W | First source tag of offered entry |
| iss_src_b | output | PTAG_W | Second source tag of offered entry |
| cm_valid | output | 1 | Oldest entry retires this cycle |
| cm_lreg | output | LREG_W | Retiring logical register |
| cm_ptag | output | PTAG_W | Retiring new tag |
| cm_prev_ptag | output | PTAG_W | Displaced tag, now releasable |
| replay_busy | output | 1 | Rollback in progress |
| rb_valid | output | 1 | Rollback step this cycle |
| rb_lreg | output | LREG_W | Logical register to restore |
| rb_restore_ptag | output | PTAG_W | Tag to map back |
| rb_free_ptag | output | PTAG_W | Tag to return to the free pool |
| redir_valid | output | 1 | Redirect to fetch |
| redir_pc | output | PC_W | Corrected fetch address |
| redir_epoch | output | EPOCH_W | New epoch |

## Verification
A stale ready flag or a missed wakeup appears as an `iss_valid` that stays low, or rises too early, in the cycle right after the tag broadcast. A corrupted slot appears on the commit fields as soon as that entry reaches the head. A pointer that drifts during rollback appears on `rb_*` within one step: the wrong register or the wrong tags, or one step too many or too few before the redirect. After the redirect, the same drift shows up as the wrong `in_idx`. A pointer off by one near the wrap shows up as a wrong `in_ready` at the full boundary.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int LREG_W  = 5;
    localparam int PTAG_W  = 6;
    localparam int PC_W    = 32;
    localparam int EPOCH_W = 2;

    typedef logic [LREG_W-1:0] lreg_t;
    typedef logic [PTAG_W-1:0] ptag_t;
    typedef logic [PC_W-1:0]   pc_t;

    // order matters: entries advance through these values
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RDY  = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } status_e;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_WALK = 1'b1
    } rp_state_e;

    typedef struct packed {
        lreg_t lreg;
        ptag_t ptag;
        ptag_t prev;
        ptag_t src_a;
        ptag_t src_b;
        logic  rdy_a;
        logic  rdy_b;
    } uop_t;

    // a source is available if already flagged or broadcast this cycle
    function automatic logic src_avail(input logic flag, input logic wake_v,
                                       input ptag_t wake_tag, input ptag_t src);
        return flag | (wake_v && (wake_tag == src));
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       rewind,
    output logic [$clog2(DEPTH):0]     head,
    output logic [$clog2(DEPTH):0]     tail,
    output logic [$clog2(DEPTH):0]     tail_last,
    output logic                       full,
    output logic                       empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (pop)
                head <= head + PTR_W'(1);
            if (push)
                tail <= tail + PTR_W'(1);
            else if (rewind)
                tail <= tail - PTR_W'(1);
        end
    end

    assign tail_last = tail - PTR_W'(1);
    assign empty     = (head == tail);
    assign full      = (head[IDX_W-1:0] == tail[IDX_W-1:0]) &&
                       (head[IDX_W] != tail[IDX_W]);

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        empty |-> (!pop && !rewind));

endmodule

// File: rtl/rob_slot.sv
module rob_slot
    import rob_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  uop_t    wr_uop,
    input  logic    wake_v,
    input  ptag_t   wake_tag,
    input  logic    take,
    input  logic    done,
    input  logic    done_misp,
    input  pc_t     done_pc,
    input  logic    clr_misp,
    output lreg_t   o_lreg,
    output ptag_t   o_ptag,
    output ptag_t   o_prev,
    output ptag_t   o_src_a,
    output ptag_t   o_src_b,
    output status_e o_st,
    output logic    o_misp,
    output pc_t     o_tgt
);
    uop_t    u;
    status_e st;
    logic    misp;
    pc_t     tgt;
    logic    na, nb, ia, ib;

    assign na = src_avail(u.rdy_a, wake_v, wake_tag, u.src_a);
    assign nb = src_avail(u.rdy_b, wake_v, wake_tag, u.src_b);
    assign ia = src_avail(wr_uop.rdy_a, wake_v, wake_tag, wr_uop.src_a);
    assign ib = src_avail(wr_uop.rdy_b, wake_v, wake_tag, wr_uop.src_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            u    <= '0;
            st   <= ST_WAIT;
            misp <= 1'b0;
            tgt  <= '0;
        end else if (wr) begin
            u       <= wr_uop;
            u.rdy_a <= ia;
            u.rdy_b <= ib;
            st      <= (ia && ib) ? ST_RDY : ST_WAIT;
            misp    <= 1'b0;
        end else begin
            u.rdy_a <= na;
            u.rdy_b <= nb;
            if (done) begin
                st   <= ST_DONE;
                misp <= done_misp;
                tgt  <= done_pc;
            end else begin
                if (take)
                    st <= ST_EXEC;
                else if (st == ST_WAIT && na && nb)
                    st <= ST_RDY;
                if (clr_misp)
                    misp <= 1'b0;
            end
        end
    end

    assign o_lreg  = u.lreg;
    assign o_ptag  = u.ptag;
    assign o_prev  = u.prev;
    assign o_src_a = u.src_a;
    assign o_src_b = u.src_b;
    assign o_st    = st;
    assign o_misp  = misp;
    assign o_tgt   = tgt;

    // a waiting entry never sits with both operands flagged ready
    assert_wait_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> !(u.rdy_a && u.rdy_b));

    // only a ready entry can be handed to execution
    assert_take_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (take && !wr && !done) |-> (st == ST_RDY));

endmodule

// File: rtl/rob_replay.sv
module rob_replay
    import rob_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               at_head,
    output logic               busy,
    output logic               undo,
    output logic               redir,
    output logic [EPOCH_W-1:0] epoch_next
);
    rp_state_e          state;
    logic [EPOCH_W-1:0] epoch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RP_IDLE;
            epoch <= '0;
        end else begin
            case (state)
                RP_IDLE: if (start) state <= RP_WALK;
                RP_WALK: if (at_head) begin
                    state <= RP_IDLE;
                    epoch <= epoch_next;
                end
                default: state <= RP_IDLE;
            endcase
        end
    end

    assign busy       = (state == RP_WALK);
    assign undo       = busy && !at_head;
    assign redir      = busy && at_head;
    assign epoch_next = epoch + EPOCH_W'(1);

    assert_redirect_epoch_R9: assert property (@(posedge clk) disable iff (rst)
        redir |=> (!busy && epoch == $past(epoch_next)));

    assert_step_continues_R8: assert property (@(posedge clk) disable iff (rst)
        undo |=> busy);

endmodule

// File: rtl/reorder_window.sv
module reorder_window
    import rob_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    output logic [$clog2(DEPTH)-1:0] in_idx,
    input  logic [LREG_W-1:0]        in_lreg,
    input  logic [PTAG_W-1:0]        in_ptag,
    input  logic [PTAG_W-1:0]        in_prev_ptag,
    input  logic [PTAG_W-1:0]        in_src_a,
    input  logic                     in_src_a_rdy,
    input  logic [PTAG_W-1:0]        in_src_b,
    input  logic                     in_src_b_rdy,
    input  logic                     wb_valid,
    input  logic [$clog2(DEPTH)-1:0] wb_idx,
    input  logic [PTAG_W-1:0]        wb_ptag,
    input  logic                     wb_mispredict,
    input  logic [PC_W-1:0]          wb_target,
    output logic                     iss_valid,
    input  logic                     iss_take,
    output logic [$clog2(DEPTH)-1:0] iss_idx,
    output logic [PTAG_W-1:0]        iss_ptag,
    output logic [PTAG_W-1:0]        iss_src_a,
    output logic [PTAG_W-1:0]        iss_src_b,
    output logic                     cm_valid,
    output logic [LREG_W-1:0]        cm_lreg,
    output logic [PTAG_W-1:0]        cm_ptag,
    output logic [PTAG_W-1:0]        cm_prev_ptag,
    output logic                     replay_busy,
    output logic                     rb_valid,
    output logic [LREG_W-1:0]        rb_lreg,
    output logic [PTAG_W-1:0]        rb_restore_ptag,
    output logic [PTAG_W-1:0]        rb_free_ptag,
    output logic                     redir_valid,
    output logic [PC_W-1:0]          redir_pc,
    output logic [EPOCH_W-1:0]       redir_epoch
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] head, tail, tail_last, count;
    logic             full, empty, push, start, undo, at_head;
    logic [IDX_W-1:0] head_idx, next_idx, last_idx, tail_idx, sel_idx;
    logic             sel_valid;
    uop_t             new_uop;

    lreg_t   s_lreg  [DEPTH];
    ptag_t   s_ptag  [DEPTH];
    ptag_t   s_prev  [DEPTH];
    ptag_t   s_src_a [DEPTH];
    ptag_t   s_src_b [DEPTH];
    status_e s_st    [DEPTH];
    logic    s_misp  [DEPTH];
    pc_t     s_tgt   [DEPTH];

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (cm_valid),
        .rewind    (undo),
        .head      (head),
        .tail      (tail),
        .tail_last (tail_last),
        .full      (full),
        .empty     (empty)
    );

    assign head_idx = head[IDX_W-1:0];
    assign tail_idx = tail[IDX_W-1:0];
    assign last_idx = tail_last[IDX_W-1:0];
    assign next_idx = head_idx + IDX_W'(1);
    assign count    = tail - head;
    assign at_head  = (tail_last == head);

    assign in_ready = !full && !replay_busy;
    assign push     = in_valid && in_ready;
    assign in_idx   = tail_idx;

    assign new_uop = '{lreg: in_lreg, ptag: in_ptag, prev: in_prev_ptag,
                       src_a: in_src_a, src_b: in_src_b,
                       rdy_a: in_src_a_rdy, rdy_b: in_src_b_rdy};

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr        (push && tail_idx == IDX_W'(i)),
            .wr_uop    (new_uop),
            .wake_v    (wb_valid),
            .wake_tag  (wb_ptag),
            .take      (iss_valid && iss_take && sel_idx == IDX_W'(i)),
            .done      (wb_valid && wb_idx == IDX_W'(i)),
            .done_misp (wb_mispredict),
            .done_pc   (wb_target),
            .clr_misp  (redir_valid && head_idx == IDX_W'(i)),
            .o_lreg    (s_lreg[i]),
            .o_ptag    (s_ptag[i]),
            .o_prev    (s_prev[i]),
            .o_src_a   (s_src_a[i]),
            .o_src_b   (s_src_b[i]),
            .o_st      (s_st[i]),
            .o_misp    (s_misp[i]),
            .o_tgt     (s_tgt[i])
        );
    end

    // in-order issue window: head, or head+1 once head has finished cleanly
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = head_idx;
        if (!replay_busy && !empty) begin
            if (s_st[head_idx] == ST_RDY) begin
                sel_valid = 1'b1;
            end else if (s_st[head_idx] == ST_DONE && !s_misp[head_idx] &&
                         count > PTR_W'(1) && s_st[next_idx] == ST_RDY) begin
                sel_valid = 1'b1;
                sel_idx   = next_idx;
            end
        end
    end

    assign iss_valid = sel_valid;
    assign iss_idx   = sel_idx;
    assign iss_ptag  = s_ptag[sel_idx];
    assign iss_src_a = s_src_a[sel_idx];
    assign iss_src_b = s_src_b[sel_idx];

    assign cm_valid     = !replay_busy && !empty && s_st[head_idx] == ST_DONE &&
                          !s_misp[head_idx];
    assign cm_lreg      = s_lreg[head_idx];
    assign cm_ptag      = s_ptag[head_idx];
    assign cm_prev_ptag = s_prev[head_idx];

    assign start = !replay_busy && !empty && s_st[head_idx] == ST_DONE &&
                   s_misp[head_idx];

    rob_replay u_replay (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .at_head    (at_head),
        .busy       (replay_busy),
        .undo       (undo),
        .redir      (redir_valid),
        .epoch_next (redir_epoch)
    );

    assign rb_valid        = undo;
    assign rb_lreg         = s_lreg[last_idx];
    assign rb_restore_ptag = s_prev[last_idx];
    assign rb_free_ptag    = s_ptag[last_idx];
    assign redir_pc        = s_tgt[head_idx];

    assert_commit_advance_R6: assert property (@(posedge clk) disable iff (rst)
        cm_valid |=> (head == $past(head) + PTR_W'(1)));

    assert_issue_window_R5: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_idx == head_idx || iss_idx == next_idx));

    assert_replay_stall_R7: assert property (@(posedge clk) disable iff (rst)
        replay_busy |-> (!iss_valid && !cm_valid && !in_ready));

    assert_walk_step_R8: assert property (@(posedge clk) disable iff (rst)
        rb_valid |=> (tail == $past(tail_last)));

    assert_resume_slot_R10: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (tail == head + PTR_W'(1)));

endmodule

// File: tb/reorder_window_tb.sv
`timescale 1ns/1ps
module reorder_window_tb;
    import rob_pkg::*;

    localparam int DEPTH = 8;
    localparam int IW    = $clog2(DEPTH);

    typedef struct packed {
        logic [LREG_W-1:0] lreg;
        logic [PTAG_W-1:0] ptag;
        logic [PTAG_W-1:0] prev;
        logic [PTAG_W-1:0] sa;
        logic [PTAG_W-1:0] sb;
        logic              ra;
        logic              rb;
    } row_t;

    // dependent chain: row1 needs row0, row2 needs rows 0 and 1
    localparam row_t TBL [4] = '{
        '{lreg: 5'd1, ptag: 6'd10, prev: 6'd1,  sa: 6'd2,  sb: 6'd3,  ra: 1'b1, rb: 1'b1},
        '{lreg: 5'd2, ptag: 6'd11, prev: 6'd2,  sa: 6'd10, sb: 6'd3,  ra: 1'b0, rb: 1'b1},
        '{lreg: 5'd1, ptag: 6'd12, prev: 6'd10, sa: 6'd11, sb: 6'd10, ra: 1'b0, rb: 1'b0},
        '{lreg: 5'd4, ptag: 6'd13, prev: 6'd4,  sa: 6'd5,  sb: 6'd6,  ra: 1'b1, rb: 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_ready;
    logic [IW-1:0] in_idx;
    logic [LREG_W-1:0] in_lreg = '0;
    logic [PTAG_W-1:0] in_ptag = '0, in_prev_ptag = '0, in_src_a = '0, in_src_b = '0;
    logic in_src_a_rdy = 0, in_src_b_rdy = 0;
    logic wb_valid = 0, wb_mispredict = 0;
    logic [IW-1:0] wb_idx = '0;
    logic [PTAG_W-1:0] wb_ptag = '0;
    logic [PC_W-1:0] wb_target = '0;
    logic iss_valid, iss_take = 0;
    logic [IW-1:0] iss_idx;
    logic [PTAG_W-1:0] iss_ptag, iss_src_a, iss_src_b;
    logic cm_valid;
    logic [LREG_W-1:0] cm_lreg;
    logic [PTAG_W-1:0] cm_ptag, cm_prev_ptag;
    logic replay_busy, rb_valid;
    logic [LREG_W-1:0] rb_lreg;
    logic [PTAG_W-1:0] rb_restore_ptag, rb_free_ptag;
    logic redir_valid;
    logic [PC_W-1:0] redir_pc;
    logic [EPOCH_W-1:0] redir_epoch;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    reorder_window #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic insert(input logic [LREG_W-1:0] l, input logic [PTAG_W-1:0] p,
                          input logic [PTAG_W-1:0] pv, input logic [PTAG_W-1:0] a,
                          input logic [PTAG_W-1:0] b, input logic ra, input logic rb);
        in_valid = 1; in_lreg = l; in_ptag = p; in_prev_ptag = pv;
        in_src_a = a; in_src_b = b; in_src_a_rdy = ra; in_src_b_rdy = rb;
        tick();
        in_valid = 0;
    endtask

    task automatic take_one();
        iss_take = 1;
        tick();
        iss_take = 0;
    endtask

    task automatic wback(input logic [IW-1:0] idx, input logic [PTAG_W-1:0] p,
                         input logic misp, input logic [PC_W-1:0] tgt);
        wb_valid = 1; wb_idx = idx; wb_ptag = p; wb_mispredict = misp; wb_target = tgt;
        tick();
        wb_valid = 0; wb_mispredict = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // reset state (R1, R9)
        chk(in_ready === 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(in_idx === '0, "R1 reset in_idx", in_idx, 0);
        chk(iss_valid === 1'b0 && cm_valid === 1'b0, "R6 reset idle", {iss_valid, cm_valid}, 0);
        chk(replay_busy === 1'b0 && rb_valid === 1'b0 && redir_valid === 1'b0,
            "R9 reset no replay", {replay_busy, rb_valid, redir_valid}, 0);

        // table-driven dependent chain (R2, R4, R5, R6)
        for (int r = 0; r < 4; r++)
            insert(TBL[r].lreg, TBL[r].ptag, TBL[r].prev, TBL[r].sa, TBL[r].sb,
                   TBL[r].ra, TBL[r].rb);
        for (int i = 0; i < 4; i++) begin
            for (int n = 0; n < 10 && !iss_valid; n++) tick();
            chk(iss_valid && iss_idx == IW'(i), "R5 in-order offer", iss_idx, i);
            chk(iss_ptag == TBL[i].ptag, "R5 offered tag", iss_ptag, TBL[i].ptag);
            take_one();
            chk(iss_valid === 1'b0, "R5 no offer while head executes", iss_valid, 0);
            wback(IW'(i), TBL[i].ptag, 1'b0, '0);
            chk(cm_valid === 1'b1, "R6 commit when done", cm_valid, 1);
            chk({cm_lreg, cm_ptag, cm_prev_ptag} == {TBL[i].lreg, TBL[i].ptag, TBL[i].prev},
                "R2 commit fields", {cm_lreg, cm_ptag, cm_prev_ptag},
                {TBL[i].lreg, TBL[i].ptag, TBL[i].prev});
            if (i < 3)
                chk(iss_valid && iss_idx == IW'(i + 1), "R4 woken successor offered",
                    iss_idx, i + 1);
            tick();
        end
        chk(cm_valid === 1'b0 && iss_valid === 1'b0, "R6 empty after drain",
            {cm_valid, iss_valid}, 0);

        // waiting head is held until a wakeup-only writeback (R3, R4)
        insert(5'd8, 6'd14, 6'd8, 6'd50, 6'd2, 1'b0, 1'b1);
        chk(iss_valid === 1'b0, "R3 waiting head not offered", iss_valid, 0);
        tick();
        chk(iss_valid === 1'b0, "R3 still waiting", iss_valid, 0);
        wback(IW'(7), 6'd50, 1'b0, '0);
        chk(iss_valid && iss_idx == IW'(4), "R4 wakeup makes head issuable", iss_idx, 4);
        take_one();
        wback(IW'(4), 6'd14, 1'b0, '0);
        chk(cm_valid && cm_ptag == 6'd14, "R6 commit waiting entry", cm_ptag, 14);
        tick();

        // wakeup captured by an insert in the same cycle (R4)
        insert(5'd9, 6'd40, 6'd9, 6'd2, 6'd3, 1'b1, 1'b1);
        take_one();
        in_valid = 1; in_lreg = 5'd10; in_ptag = 6'd41; in_prev_ptag = 6'd10;
        in_src_a = 6'd40; in_src_a_rdy = 0; in_src_b = 6'd2; in_src_b_rdy = 1;
        wback(IW'(5), 6'd40, 1'b0, '0);
        in_valid = 0;
        chk(cm_valid && cm_ptag == 6'd40, "R6 commit producer", cm_ptag, 40);
        chk(iss_valid && iss_idx == IW'(6), "R4 same-cycle insert woken", iss_idx, 6);
        tick();
        take_one();
        wback(IW'(6), 6'd41, 1'b0, '0);
        chk(cm_valid && cm_ptag == 6'd41, "R6 commit consumer", cm_ptag, 41);
        tick();

        // fill across the wrap, refuse extra, drain (R1, R11)
        for (int k = 0; k < DEPTH; k++) begin
            chk(in_ready === 1'b1, "R11 room before full", in_ready, 1);
            chk(in_idx == IW'((7 + k) % DEPTH), "R1 slot sequence wraps", in_idx, (7 + k) % DEPTH);
            insert(LREG_W'(k + 1), PTAG_W'(16 + k), '0, 6'd2, 6'd3, 1'b1, 1'b1);
        end
        chk(in_ready === 1'b0, "R1 full refuses", in_ready, 0);
        insert(5'd31, 6'd63, 6'd0, 6'd2, 6'd3, 1'b1, 1'b1);
        for (int k = 0; k < DEPTH; k++) begin
            chk(iss_valid && iss_idx == IW'((7 + k) % DEPTH), "R11 drain order", iss_idx,
                (7 + k) % DEPTH);
            take_one();
            wback(IW'((7 + k) % DEPTH), PTAG_W'(16 + k), 1'b0, '0);
            chk(cm_valid && cm_ptag == PTAG_W'(16 + k), "R2 drain commit tag", cm_ptag, 16 + k);
            tick();
        end
        chk(cm_valid === 1'b0 && iss_valid === 1'b0 && in_ready === 1'b1,
            "R1 refused insert left no entry", {cm_valid, iss_valid, in_ready}, 3'b001);

        // mispredict with three younger entries (R7, R8, R9, R10)
        insert(5'd3, 6'd20, 6'd30, 6'd2, 6'd3, 1'b1, 1'b1);
        insert(5'd5, 6'd21, 6'd31, 6'd2, 6'd3, 1'b1, 1'b1);
        insert(5'd6, 6'd22, 6'd32, 6'd2, 6'd3, 1'b1, 1'b1);
        insert(5'd7, 6'd23, 6'd33, 6'd2, 6'd3, 1'b1, 1'b1);
        chk(iss_idx == IW'(7), "R5 head offered", iss_idx, 7);
        take_one();
        wback(IW'(7), 6'd20, 1'b1, 32'h1234);
        chk(cm_valid === 1'b0, "R6 mispredicted head held", cm_valid, 0);
        chk(iss_valid === 1'b0, "R5 no offer after mispredict", iss_valid, 0);
        chk(replay_busy === 1'b0, "R7 replay starts next edge", replay_busy, 0);
        tick();
        chk(replay_busy && !in_ready && !iss_valid && !cm_valid, "R7 stall during replay",
            {replay_busy, in_ready, iss_valid, cm_valid}, 4'b1000);
        chk(rb_valid && {rb_lreg, rb_restore_ptag, rb_free_ptag} == {5'd7, 6'd33, 6'd23},
            "R8 step youngest", {rb_lreg, rb_restore_ptag, rb_free_ptag}, {5'd7, 6'd33, 6'd23});
        tick();
        chk(rb_valid && {rb_lreg, rb_restore_ptag, rb_free_ptag} == {5'd6, 6'd32, 6'd22},
            "R8 step second", {rb_lreg, rb_restore_ptag, rb_free_ptag}, {5'd6, 6'd32, 6'd22});
        tick();
        chk(rb_valid && {rb_lreg, rb_restore_ptag, rb_free_ptag} == {5'd5, 6'd31, 6'd21},
            "R8 step third", {rb_lreg, rb_restore_ptag, rb_free_ptag}, {5'd5, 6'd31, 6'd21});
        tick();
        chk(!rb_valid && redir_valid, "R8 walk stops at mispredict", {rb_valid, redir_valid}, 2'b01);
        chk(redir_pc == 32'h1234 && redir_epoch == EPOCH_W'(1), "R9 redirect pc and epoch",
            {redir_pc, redir_epoch}, {32'h1234, EPOCH_W'(1)});
        tick();
        chk(!replay_busy && !redir_valid, "R9 redirect one cycle", {replay_busy, redir_valid}, 0);
        chk(cm_valid && cm_ptag == 6'd20, "R10 mispredicting entry commits", cm_ptag, 20);
        chk(in_idx == IW'(0), "R10 tail rewound", in_idx, 0);
        insert(5'd9, 6'd24, 6'd34, 6'd2, 6'd3, 1'b1, 1'b1);
        chk(iss_valid && iss_idx == IW'(0) && iss_ptag == 6'd24, "R10 new entry after rollback",
            iss_ptag, 24);

        // mispredict with nothing younger (R8, R9)
        take_one();
        wback(IW'(0), 6'd24, 1'b1, 32'h40);
        tick();
        chk(replay_busy && redir_valid && !rb_valid, "R8 empty walk", {replay_busy, redir_valid, rb_valid},
            3'b110);
        chk(redir_pc == 32'h40 && redir_epoch == EPOCH_W'(2), "R9 second epoch",
            {redir_pc, redir_epoch}, {32'h40, EPOCH_W'(2)});
        tick();
        chk(cm_valid && cm_ptag == 6'd24, "R10 commit after empty walk", cm_ptag, 24);
        tick();
        chk(cm_valid === 1'b0 && in_ready === 1'b1, "R6 empty at end", {cm_valid, in_ready}, 2'b01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule